// File: doc/BRIEF.md
# Dual-Bank Flash Command Controller

This block is a synthesizable behavioural model of a two-bank NOR-style flash part whose storage is a small register array. A host drives it through an asynchronous-style bus made of chip enable, write enable, output enable, address and data lines. The block samples that bus on a system clock. It decodes the unlock-style program and sector-erase command sequences and runs each accepted operation as a timed busy period inside one bank. While that operation runs, reads to the other bank keep returning array data.

A read aimed at the busy bank returns a status byte instead of array data. Bit 7 of that byte is the complement of the programmed bit 7. Bits 6 and 2 invert from one read to the next. A ready/busy output stays low for the whole operation. When the operation ends, the block returns to array reads by itself. Each sector has a protection input, and a byte-mode input narrows the data path to eight lines and adds a lane-select address bit.

Top module: `dbflash_ctrl`

## Requirements
- R1: After reset every array word reads 16'hFFFF, `rdy` is 1 and `dq_oe` is 0. `dq_oe` is 1 only in cycles that follow a sample with `ce_n`=0 and `oe_n`=0.
- R2: The program sequence is four writes: 8'hAA at word address 11'h555, 8'h55 at 11'h2AA, 8'hA0 at 11'h555, then data at the target address. The target word becomes old AND new. `rdy` is 0 for exactly PROG_CYC clock cycles, starting at the edge that takes the last write. The block then returns to array reads without any reset command.
- R3: The erase sequence is six writes: AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then 8'h30 at any address inside the sector. Every word of that sector becomes 16'hFFFF and all other words are unchanged. `rdy` is 0 for exactly ERASE_CYC cycles.
- R4: While busy, a read to a word of the other bank returns that word's array data.
- R5: While busy, a read to the busy bank returns a status word whose bits [15:8] are 0. Bit 7 is the complement of bit 7 of the datum being programmed, and 0 during an erase. Bit 6 inverts between successive status reads.
- R6: Bit 2 of the status inverts between successive status reads that fall inside the sector being erased. Bit 2 keeps its value on status reads outside that sector and on all status reads during a program.
- R7: A program or erase whose target sector has its `prot_mask` bit set is dropped. `rdy` stays 1 and the array does not change.
- R8: A write that does not match the next expected step of a sequence returns the decoder to idle and changes nothing. A later complete sequence works.
- R9: With `byte_mode`=1, reads return the selected byte on `dq_out[7:0]` with `dq_out[15:8]`=0, where `byte_sel`=1 selects the high byte. A program writes `dq_in[7:0]` into the selected lane only, and `dq_in[15:8]` is ignored. Command writes still compare the word address and `dq_in[7:0]`.
- R10: Bank 0 is the lowest SECTORS/8, SECTORS/4 or SECTORS/2 sectors for SPLIT_SEL 0, 1 or 2, and bank 1 is the rest. With the defaults, words 0–15 form bank 0.
- R11: While `rdy` is 0, every write is ignored: it is neither decoded nor allowed to start an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which the bus is sampled |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; one write per low pulse |
| oe_n | input | 1 | Output enable, active low; one read per low pulse |
| byte_mode | input | 1 | 1 selects the 8-bit data path |
| byte_sel | input | 1 | Byte-lane address bit used in byte mode (1 = high byte) |
| addr | input | AW | Word address |
| dq_in | input | 16 | Write data |
| prot_mask | input | SECTORS | Per-sector protection flags |
| dq_out | output | 16 | Read data or status, registered |
| dq_oe | output | 1 | Read data valid / output drive |
| rdy | output | 1 | Ready (1) / busy (0) |

## Verification
The command decoder acts at the clock edge that samples the falling edge of `we_n`. `rdy` therefore drops at that edge, and the bench checks it at the following falling clock edge. `dq_out` is registered at the edge that sees `oe_n` fall, so each read task samples exactly one clock later. The busy duration is measured by counting falling edges on which `rdy` is low. The array update lands on the same edge that raises `rdy`, so reads issued after `rdy` returns must already show the new contents.

// File: rtl/dbflash_pkg.sv
package dbflash_pkg;

  typedef enum logic [2:0] {
    CS_IDLE, CS_UNL1, CS_UNL2, CS_PROG, CS_ERA1, CS_ERA2, CS_ERA3
  } cmd_state_e;

  localparam logic [7:0] KEY_A     = 8'hAA;
  localparam logic [7:0] KEY_B     = 8'h55;
  localparam logic [7:0] OP_PROG   = 8'hA0;
  localparam logic [7:0] OP_ERSETUP = 8'h80;
  localparam logic [7:0] OP_ERSECT = 8'h30;

  // programming can only clear bits
  function automatic logic [15:0] merge_program(input logic [15:0] old_w,
                                                input logic [15:0] new_w);
    return old_w & new_w;
  endfunction

  // place write data into a word, padding the untouched lane with ones
  function automatic logic [15:0] lane_word(input logic byte_mode, input logic lane,
                                            input logic [15:0] d);
    if (!byte_mode) return d;
    return lane ? {d[7:0], 8'hFF} : {8'hFF, d[7:0]};
  endfunction

  // select what a read presents in the current width mode
  function automatic logic [15:0] lane_read(input logic byte_mode, input logic lane,
                                            input logic [15:0] w);
    if (!byte_mode) return w;
    return lane ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  function automatic logic [15:0] status_word(input logic poll7, input logic t6,
                                              input logic t2);
    return {8'h00, ~poll7, t6, 3'b000, t2, 2'b00};
  endfunction

endpackage

// File: rtl/dbflash_bus_sync.sv
module dbflash_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic write_stb,
  output logic read_stb,
  output logic read_active
);
  logic we_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
    end
  end

  assign write_stb   = !ce_n && !we_n && we_q && oe_n;
  assign read_active = !ce_n && !oe_n && we_n;
  assign read_stb    = read_active && oe_q;
endmodule

// File: rtl/dbflash_cmd_seq.sv
module dbflash_cmd_seq
  import dbflash_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          write_stb,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data8,
  input  logic          busy,
  input  logic          target_prot,
  output logic          start_prog,
  output logic          start_erase
);
  localparam logic [AW-1:0] ADDR_U1 = AW'(11'h555);
  localparam logic [AW-1:0] ADDR_U2 = AW'(11'h2AA);

  cmd_state_e state, state_d;
  logic at_u1, at_u2;

  assign at_u1 = (addr == ADDR_U1);
  assign at_u2 = (addr == ADDR_U2);

  always_comb begin
    state_d     = state;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    if (write_stb && !busy) begin
      state_d = CS_IDLE;
      unique case (state)
        CS_IDLE: if (at_u1 && data8 == KEY_A) state_d = CS_UNL1;
        CS_UNL1: if (at_u2 && data8 == KEY_B) state_d = CS_UNL2;
        CS_UNL2: begin
          if (at_u1 && data8 == OP_PROG)         state_d = CS_PROG;
          else if (at_u1 && data8 == OP_ERSETUP) state_d = CS_ERA1;
        end
        CS_PROG: start_prog = !target_prot;
        CS_ERA1: if (at_u1 && data8 == KEY_A) state_d = CS_ERA2;
        CS_ERA2: if (at_u2 && data8 == KEY_B) state_d = CS_ERA3;
        CS_ERA3: start_erase = (data8 == OP_ERSECT) && !target_prot;
        default: state_d = CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CS_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/dbflash_engine.sv
module dbflash_engine
  import dbflash_pkg::*;
#(
  parameter int ARR_AW    = 6,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 48,
  parameter int CNT_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic [ARR_AW-1:0] addr_idx,
  input  logic              byte_mode,
  input  logic              lane,
  input  logic [15:0]       data,
  input  logic              stat_rd,
  input  logic              stat_rd_sect,
  output logic              busy,
  output logic              done,
  output logic              op_erase,
  output logic [ARR_AW-1:0] tgt_idx,
  output logic [15:0]       tgt_word,
  output logic              poll7,
  output logic              t6,
  output logic              t2
);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      op_erase <= 1'b0;
      tgt_idx  <= '0;
      tgt_word <= 16'hFFFF;
      poll7    <= 1'b1;
      t6       <= 1'b0;
      t2       <= 1'b0;
    end else begin
      if (start_prog || start_erase) begin
        busy     <= 1'b1;
        cnt      <= start_erase ? ERASE_LOAD : PROG_LOAD;
        op_erase <= start_erase;
        tgt_idx  <= addr_idx;
        tgt_word <= lane_word(byte_mode, lane, data);
        poll7    <= start_erase ? 1'b1 : data[7];
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
      if (stat_rd)      t6 <= ~t6;
      if (stat_rd_sect) t2 <= ~t2;
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/dbflash_array.sv
module dbflash_array
  import dbflash_pkg::*;
#(
  parameter int ARR_AW = 6,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              op_erase,
  input  logic [ARR_AW-1:0] tgt_idx,
  input  logic [15:0]       tgt_word,
  input  logic [ARR_AW-1:0] rd_idx,
  output logic [15:0]       rd_word
);
  localparam int WORDS = 1 << ARR_AW;

  logic [15:0] mem [WORDS];
  logic [SECT_W-1:0] tgt_sect;

  function automatic logic [SECT_W-1:0] sect_of_int(input int i);
    logic [ARR_AW-1:0] v;
    v = ARR_AW'(i);
    return v[ARR_AW-1 -: SECT_W];
  endfunction

  assign tgt_sect = tgt_idx[ARR_AW-1 -: SECT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
    end else if (done) begin
      if (op_erase) begin
        for (int i = 0; i < WORDS; i++)
          if (sect_of_int(i) == tgt_sect) mem[i] <= 16'hFFFF;
      end else begin
        mem[tgt_idx] <= merge_program(mem[tgt_idx], tgt_word);
      end
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/dbflash_ctrl.sv
module dbflash_ctrl
  import dbflash_pkg::*;
#(
  parameter int AW        = 11,
  parameter int ARR_AW    = 6,
  parameter int SECTORS   = 8,
  parameter int SPLIT_SEL = 1,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic               byte_mode,
  input  logic               byte_sel,
  input  logic [AW-1:0]      addr,
  input  logic [15:0]        dq_in,
  input  logic [SECTORS-1:0] prot_mask,
  output logic [15:0]        dq_out,
  output logic               dq_oe,
  output logic               rdy
);
  localparam int SECT_W     = $clog2(SECTORS);
  localparam int MAX_CYC    = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int BANK0_SECT = (SPLIT_SEL == 0) ? SECTORS / 8 :
                              (SPLIT_SEL == 1) ? SECTORS / 4 : SECTORS / 2;

  // bank 1 holds every sector at or above the split point
  function automatic logic bank_of(input logic [SECT_W-1:0] s);
    return int'(s) >= BANK0_SECT;
  endfunction

  logic              write_stb, read_stb, read_active;
  logic              start_prog, start_erase;
  logic              busy, done, op_erase, poll7, t6, t2;
  logic [ARR_AW-1:0] idx, tgt_idx;
  logic [SECT_W-1:0] sect, tgt_sect;
  logic [15:0]       tgt_word, rd_word, status, rd_value;
  logic              target_prot, hit_busy, stat_rd, stat_rd_sect;

  assign idx         = addr[ARR_AW-1:0];
  assign sect        = idx[ARR_AW-1 -: SECT_W];
  assign tgt_sect    = tgt_idx[ARR_AW-1 -: SECT_W];
  assign target_prot = prot_mask[sect];

  dbflash_bus_sync u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .write_stb(write_stb), .read_stb(read_stb), .read_active(read_active)
  );

  dbflash_cmd_seq #(.AW(AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .write_stb(write_stb), .addr(addr),
    .data8(dq_in[7:0]), .busy(busy), .target_prot(target_prot),
    .start_prog(start_prog), .start_erase(start_erase)
  );

  dbflash_engine #(
    .ARR_AW(ARR_AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .CNT_W(CNT_W)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
    .addr_idx(idx), .byte_mode(byte_mode), .lane(byte_sel), .data(dq_in),
    .stat_rd(stat_rd), .stat_rd_sect(stat_rd_sect),
    .busy(busy), .done(done), .op_erase(op_erase), .tgt_idx(tgt_idx),
    .tgt_word(tgt_word), .poll7(poll7), .t6(t6), .t2(t2)
  );

  dbflash_array #(.ARR_AW(ARR_AW), .SECT_W(SECT_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .done(done), .op_erase(op_erase),
    .tgt_idx(tgt_idx), .tgt_word(tgt_word), .rd_idx(idx), .rd_word(rd_word)
  );

  // read steering: busy bank gives status, the other bank gives data
  assign hit_busy     = busy && (bank_of(sect) == bank_of(tgt_sect));
  assign stat_rd      = read_stb && hit_busy;
  assign stat_rd_sect = stat_rd && op_erase && (sect == tgt_sect);
  assign status       = status_word(poll7, t6 ^ stat_rd, t2 ^ stat_rd_sect);
  assign rd_value     = hit_busy ? status : lane_read(byte_mode, byte_sel, rd_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else if (read_active) begin
      dq_out <= rd_value;
      dq_oe  <= 1'b1;
    end else begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end
  end

  assign rdy = !busy;
endmodule

// File: rtl/dbflash_ctrl_chk.sv
module dbflash_ctrl_chk #(
  parameter int SECT_W    = 3,
  parameter int SECTORS   = 8,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rdy,
  input logic               busy,
  input logic               done,
  input logic               op_erase,
  input logic               start_prog,
  input logic               start_erase,
  input logic               write_stb,
  input logic [SECT_W-1:0]  tgt_sect,
  input logic [SECTORS-1:0] prot_mask,
  input logic               dq_oe,
  input logic               ce_n,
  input logic               oe_n
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         busy_len <= 0;
    else if (start_prog || start_erase) busy_len <= 1;
    else if (busy && !done)             busy_len <= busy_len + 1;
  end

  assert_start_drops_rdy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase) |=> !rdy);

  assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_len == (op_erase ? ERASE_CYC : PROG_CYC));

  assert_rdy_returns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rdy);

  assert_no_protected_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !prot_mask[tgt_sect]);

  assert_busy_ignores_writes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && write_stb) |-> !(start_prog || start_erase));

  assert_oe_only_on_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!ce_n && !oe_n));
endmodule

bind dbflash_ctrl dbflash_ctrl_chk #(
  .SECT_W(SECT_W), .SECTORS(SECTORS), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .busy(busy), .done(done),
  .op_erase(op_erase), .start_prog(start_prog), .start_erase(start_erase),
  .write_stb(write_stb), .tgt_sect(tgt_sect), .prot_mask(prot_mask),
  .dq_oe(dq_oe), .ce_n(ce_n), .oe_n(oe_n)
);

// File: tb/dbflash_ctrl_bench.sv
module dbflash_ctrl_bench;
  localparam int AW = 11;
  localparam int SECTORS = 8;
  localparam int PCYC = 40;
  localparam int ECYC = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic byte_mode = 1'b0, byte_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [SECTORS-1:0] prot_mask = '0;
  logic [15:0] dq_out;
  logic dq_oe, rdy;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dbflash_ctrl #(
    .AW(AW), .ARR_AW(6), .SECTORS(SECTORS), .SPLIT_SEL(1),
    .PROG_CYC(PCYC), .ERASE_CYC(ECYC)
  ) u_dbflash_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .byte_mode(byte_mode), .byte_sel(byte_sel), .addr(addr), .dq_in(dq_in),
    .prot_mask(prot_mask), .dq_out(dq_out), .dq_oe(dq_oe), .rdy(rdy)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic lane, output logic [15:0] d);
    @(negedge clk);
    addr = a; byte_sel = lane; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    d = dq_out;
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic do_program(input logic [AW-1:0] a, input logic [15:0] d);
    bus_write(11'h555, 16'h00AA);
    bus_write(11'h2AA, 16'h0055);
    bus_write(11'h555, 16'h00A0);
    bus_write(a, d);
  endtask

  task automatic do_erase(input logic [AW-1:0] a);
    bus_write(11'h555, 16'h00AA);
    bus_write(11'h2AA, 16'h0055);
    bus_write(11'h555, 16'h0080);
    bus_write(11'h555, 16'h00AA);
    bus_write(11'h2AA, 16'h0055);
    bus_write(a, 16'h0030);
  endtask

  task automatic measure_busy(output int n);
    n = 0;
    while (!rdy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle(input string tag);
    int k = 0;
    while (!rdy && k < 1000) begin
      k++;
      @(negedge clk);
    end
    check(tag, {31'd0, rdy}, 32'd1);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 rdy after reset", {31'd0, rdy}, 32'd1);
    check("R1 dq_oe after reset", {31'd0, dq_oe}, 32'd0);
    bus_read(11'd0, 1'b0, d);
    check("R1 word0 erased", {16'd0, d}, 32'h0000FFFF);
    bus_read(11'd63, 1'b0, d);
    check("R1 word63 erased", {16'd0, d}, 32'h0000FFFF);
  endtask

  task automatic t_program();
    logic [15:0] d;
    int n;
    do_program(11'd3, 16'h5A3C);
    measure_busy(n);
    check("R2 program busy cycles", n, PCYC);
    bus_read(11'd3, 1'b0, d);
    check("R2 program data", {16'd0, d}, 32'h00005A3C);
    do_program(11'd3, 16'hF0FF);
    wait_idle("R2 second program finishes");
    bus_read(11'd3, 1'b0, d);
    check("R2 program only clears bits", {16'd0, d}, 32'h0000503C);
  endtask

  task automatic t_concurrent();
    logic [15:0] d, s1, s2;
    do_program(11'd40, 16'h1234);
    check("R2 rdy low after last write", {31'd0, rdy}, 32'd0);
    bus_read(11'd3, 1'b0, d);
    check("R4 idle bank read during program", {16'd0, d}, 32'h0000503C);
    bus_read(11'd40, 1'b0, s1);
    check("R5 poll bit7 complement", {31'd0, s1[7]}, 32'd1);
    check("R5 status upper byte", {24'd0, s1[15:8]}, 32'd0);
    bus_read(11'd47, 1'b0, s2);
    check("R5 bit6 toggles", {31'd0, s2[6]}, {31'd0, ~s1[6]});
    check("R6 bit2 steady during program", {31'd0, s2[2]}, {31'd0, s1[2]});
    bus_read(11'd3, 1'b0, d);
    check("R4 idle bank read again", {16'd0, d}, 32'h0000503C);
    wait_idle("R2 concurrent program finishes");
    bus_read(11'd40, 1'b0, d);
    check("R2 auto return to array read", {16'd0, d}, 32'h00001234);
  endtask

  task automatic t_erase();
    logic [15:0] d, s1, s2, s3;
    int n;
    do_program(11'd8, 16'h00FF);
    wait_idle("R3 setup program");
    do_erase(11'd2);
    bus_read(11'd4, 1'b0, s1);
    check("R5 erase poll bit7 zero", {31'd0, s1[7]}, 32'd0);
    bus_read(11'd6, 1'b0, s2);
    check("R6 bit2 toggles in erased sector", {31'd0, s2[2]}, {31'd0, ~s1[2]});
    check("R5 bit6 toggles during erase", {31'd0, s2[6]}, {31'd0, ~s1[6]});
    bus_read(11'd9, 1'b0, s3);
    check("R6 bit2 steady outside sector", {31'd0, s3[2]}, {31'd0, s2[2]});
    check("R10 word9 same bank gives status", {24'd0, s3[15:8]}, 32'd0);
    bus_read(11'd20, 1'b0, d);
    check("R4 other bank during erase", {16'd0, d}, 32'h0000FFFF);
    wait_idle("R3 erase finishes");
    bus_read(11'd3, 1'b0, d);
    check("R3 erased word", {16'd0, d}, 32'h0000FFFF);
    bus_read(11'd8, 1'b0, d);
    check("R3 neighbour sector intact", {16'd0, d}, 32'h000000FF);
    do_erase(11'd60);
    measure_busy(n);
    check("R3 erase busy cycles", n, ECYC);
  endtask

  task automatic t_protect();
    logic [15:0] d;
    do_program(11'd49, 16'h0F0F);
    wait_idle("R7 setup program");
    prot_mask = 8'b0100_0000;
    do_program(11'd50, 16'h0000);
    check("R7 protected program no busy", {31'd0, rdy}, 32'd1);
    bus_read(11'd50, 1'b0, d);
    check("R7 protected word unchanged", {16'd0, d}, 32'h0000FFFF);
    do_erase(11'd49);
    check("R7 protected erase no busy", {31'd0, rdy}, 32'd1);
    bus_read(11'd49, 1'b0, d);
    check("R7 protected sector kept", {16'd0, d}, 32'h00000F0F);
    prot_mask = '0;
  endtask

  task automatic t_abort();
    logic [15:0] d;
    bus_write(11'h555, 16'h00AA);
    bus_write(11'h2AA, 16'h0055);
    bus_write(11'h555, 16'h0012);
    bus_write(11'h555, 16'h00A0);
    bus_write(11'd10, 16'h0000);
    check("R8 aborted sequence no busy", {31'd0, rdy}, 32'd1);
    bus_read(11'd10, 1'b0, d);
    check("R8 aborted sequence no change", {16'd0, d}, 32'h0000FFFF);
    do_program(11'd10, 16'hAAAA);
    wait_idle("R8 program after abort");
    bus_read(11'd10, 1'b0, d);
    check("R8 sequence works after abort", {16'd0, d}, 32'h0000AAAA);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] d;
    do_program(11'd11, 16'h1111);
    do_program(11'd12, 16'h0000);
    wait_idle("R11 first program finishes");
    check("R11 no second operation started", {31'd0, rdy}, 32'd1);
    bus_read(11'd12, 1'b0, d);
    check("R11 write during busy ignored", {16'd0, d}, 32'h0000FFFF);
    bus_read(11'd11, 1'b0, d);
    check("R11 running program completed", {16'd0, d}, 32'h00001111);
  endtask

  task automatic t_byte();
    logic [15:0] d;
    byte_mode = 1'b1;
    bus_read(11'd10, 1'b0, d);
    check("R9 byte read low lane", {16'd0, d}, 32'h000000AA);
    @(negedge clk);
    byte_sel = 1'b1;
    do_program(11'd13, 16'h003C);
    wait_idle("R9 byte program finishes");
    bus_read(11'd13, 1'b1, d);
    check("R9 byte read high lane", {16'd0, d}, 32'h0000003C);
    bus_read(11'd13, 1'b0, d);
    check("R9 other lane untouched", {16'd0, d}, 32'h000000FF);
    byte_mode = 1'b0;
    bus_read(11'd13, 1'b0, d);
    check("R9 word view of byte program", {16'd0, d}, 32'h00003CFF);
    byte_sel = 1'b0;
  endtask

  task automatic t_split();
    logic [15:0] d;
    do_program(11'd16, 16'h7777);
    bus_read(11'd15, 1'b0, d);
    check("R10 word15 is bank0 data", {16'd0, d}, 32'h0000FFFF);
    bus_read(11'd17, 1'b0, d);
    check("R10 word17 is busy-bank status", {16'd0, d[15:7]}, 32'h00000001);
    wait_idle("R10 program at split finishes");
    do_program(11'd8, 16'h0000);
    bus_read(11'd16, 1'b0, d);
    check("R10 word16 is bank1 data", {16'd0, d}, 32'h00007777);
    bus_read(11'd0, 1'b0, d);
    check("R10 word0 is busy-bank status", {24'd0, d[15:8]}, 32'd0);
    check("R10 word0 poll bit", {31'd0, d[7]}, 32'd1);
    wait_idle("R10 second program finishes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_concurrent();
    t_erase();
    t_protect();
    t_abort();
    t_busy_ignore();
    t_byte();
    t_split();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule